// File: doc/BRIEF.md
# Field Threshold Output Switch with Hidden or Visible Hysteresis

This block turns a stream of digitized magnetic-field samples into a single digital output bit. The output records whether the field is on the tooth side (above the switching threshold) or the notch side (below it). The threshold comes from a separate calibration stage. This block only compares against it and decides when the output may change.

Two hysteresis styles are offered.

- **Hidden style.** The output changes exactly at the threshold, but only after an arming level, placed a half-width above or below the threshold, has been crossed. This rejects chatter without moving the observed switch point. A fallback rule lets the output return to the notch side when the field drops back below the lower arming level, even if it never reached the upper one. This way no tooth is missed.
- **Visible style.** The output switches at an on level (threshold plus half-width) when rising and at an off level (threshold minus half-width) when falling.

An invert bit selects the output polarity. A hold input freezes the output and all internal state. A one-cycle strobe marks every change of the output and feeds the calibrator.

Samples arrive over a valid/ready stream. The block never applies back-pressure: ready is high in every cycle, including reset and hold. A sample is consumed in any cycle where valid is high. A sample that arrives while hold is high is consumed and discarded.

Top module: `hhs_switch`

## Requirements
- R1: After reset the output is high, the strobe is low and the block is disarmed. In hidden style, a sample above the threshold that lies inside the arming band (neither below threshold−half-width nor above threshold+half-width) does not switch the output.
- R2: In hidden style, on the notch side, the block is armed once an accepted sample is below threshold−half-width or above threshold+half-width. An armed block moves to the tooth side on the first accepted sample strictly greater than the threshold, in the same sample that arms it if that sample qualifies.
- R3: After any side change in hidden style the block is disarmed. Further threshold recrossings that stay inside the arming band cause no switch.
- R4: In hidden style, on the tooth side, the block is armed once a sample is above threshold+half-width. An armed block moves to the notch side on the first accepted sample strictly less than the threshold.
- R5: In hidden style, after a move to the tooth side, a sample below threshold−half-width also arms the block. That sample, being below the threshold, returns the block to the notch side immediately without the field ever reaching the upper level.
- R6: In visible style, the notch-to-tooth switch happens on a sample strictly greater than threshold+half-width. The tooth-to-notch switch happens on a sample strictly less than threshold−half-width.
- R7: Polarity. Whenever hold is low, the output is registered as 0 on the tooth side and 1 on the notch side when the invert input is 0, and the reverse when it is 1. A change of the invert input alone therefore changes the output one cycle later.
- R8: While hold is high, the output, the side and the arming state keep their values and the strobe stays low, whatever samples arrive.
- R9: The strobe is high for exactly the one cycle following each output change, and the output changes in no other cycle.
- R10: Ready is high in every cycle. A sample with valid low changes neither the side nor the arming state.
- R11: A sample exactly equal to the threshold (or to a level in visible style) causes no switch. Level arithmetic is one bit wider than the sample, so a threshold near full scale plus the half-width does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always 1 |
| smp_data | input | SMP_W | Signed two's-complement field sample |
| thr_level | input | SMP_W | Signed switching threshold |
| hys_half | input | HYS_W | Unsigned hysteresis half-width |
| hys_visible | input | 1 | 0 selects hidden style, 1 selects visible style |
| out_invert | input | 1 | 0 selects low-on-tooth polarity, 1 selects high-on-tooth |
| out_hold | input | 1 | Freeze output and internal state |
| sw_out | output | 1 | Switch output bit |
| sw_strobe | output | 1 | One-cycle pulse after each output change |

## Verification
The assertions assume the following about the inputs:

- The threshold, the half-width and the mode stay meaningful between the cycle a sample is accepted and the cycle its result is seen.
- The half-width is narrower than the sample word, so the widened levels never overflow.

The stimulus respects these limits. Thresholds are drawn from a window well inside the sample range, half-widths from a small unsigned range, and samples within a bounded distance of the threshold. Mode and polarity change only occasionally, so long runs of each style occur. Directed sequences place samples exactly on the threshold and on both arming levels. They also drive the drop-below-lower-level fallback, hold over a sample that would otherwise switch, and invert toggles with no sample.

// File: rtl/hhs_pkg.sv
package hhs_pkg;
  typedef enum logic {
    HYS_HIDDEN  = 1'b0,
    HYS_VISIBLE = 1'b1
  } hys_style_e;

  // signed widening of a sample-width word by one bit
  function automatic logic signed [16:0] widen16(input logic signed [15:0] v);
    return {v[15], v};
  endfunction
endpackage

// File: rtl/hhs_levels.sv
module hhs_levels #(
  parameter int SMP_W = 12,
  parameter int HYS_W = 8
) (
  input  logic [SMP_W-1:0]        thr_i,
  input  logic [HYS_W-1:0]        hys_i,
  output logic signed [SMP_W:0]   thr_x,
  output logic signed [SMP_W:0]   up_x,
  output logic signed [SMP_W:0]   lo_x
);
  localparam int XW  = SMP_W + 1;
  localparam int PAD = XW - HYS_W;

  logic signed [XW-1:0] hys_x;

  always_comb begin
    thr_x = $signed({thr_i[SMP_W-1], thr_i});
    hys_x = $signed({{PAD{1'b0}}, hys_i});
    up_x  = thr_x + hys_x;
    lo_x  = thr_x - hys_x;
  end
endmodule

// File: rtl/hhs_decide.sv
module hhs_decide #(
  parameter int SMP_W = 12
) (
  input  logic                   take_i,
  input  hhs_pkg::hys_style_e    style_i,
  input  logic signed [SMP_W:0]  smp_x,
  input  logic signed [SMP_W:0]  thr_x,
  input  logic signed [SMP_W:0]  up_x,
  input  logic signed [SMP_W:0]  lo_x,
  input  logic                   tooth_i,
  input  logic                   armed_i,
  output logic                   flip_o,
  output logic                   armed_nxt_o
);
  import hhs_pkg::*;

  logic below_lo, above_up, above_thr, below_thr, arm_now;
  logic rise_ok, fall_ok;

  always_comb begin
    below_lo  = smp_x < lo_x;
    above_up  = smp_x > up_x;
    above_thr = smp_x > thr_x;
    below_thr = smp_x < thr_x;
    arm_now   = armed_i | below_lo | above_up;
    if (style_i == HYS_VISIBLE) begin
      rise_ok = !tooth_i && above_up;
      fall_ok = tooth_i && below_lo;
    end else begin
      rise_ok = !tooth_i && arm_now && above_thr;
      fall_ok = tooth_i && arm_now && below_thr;
    end
    flip_o = take_i && (rise_ok || fall_ok);
    if (!take_i)     armed_nxt_o = armed_i;
    else if (flip_o) armed_nxt_o = 1'b0;
    else             armed_nxt_o = arm_now;
  end
endmodule

// File: rtl/hhs_state.sv
module hhs_state (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic invert_i,
  input  logic flip_i,
  input  logic armed_nxt_i,
  output logic tooth_q,
  output logic armed_q,
  output logic out_q,
  output logic evt_q
);
  logic tooth_n, out_n;

  always_comb begin
    tooth_n = tooth_q ^ flip_i;
    if (hold_i) out_n = out_q;
    else        out_n = invert_i ? tooth_n : ~tooth_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tooth_q <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= 1'b1;
      evt_q   <= 1'b0;
    end else begin
      tooth_q <= tooth_n;
      armed_q <= armed_nxt_i;
      out_q   <= out_n;
      evt_q   <= out_n != out_q;
    end
  end

  AST_STROBE_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> (out_q != $past(out_q)));                              // R9
  AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_q |-> $stable(out_q));                                      // R9
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!evt_q && $stable(out_q) && $stable(tooth_q) && $stable(armed_q))); // R8
endmodule

// File: rtl/hhs_switch.sv
module hhs_switch #(
  parameter int SMP_W = 12,
  parameter int HYS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [SMP_W-1:0] thr_level,
  input  logic [HYS_W-1:0] hys_half,
  input  logic             hys_visible,
  input  logic             out_invert,
  input  logic             out_hold,
  output logic             sw_out,
  output logic             sw_strobe
);
  import hhs_pkg::*;

  localparam int XW = SMP_W + 1;

  logic signed [XW-1:0] thr_x, up_x, lo_x, smp_x;
  logic                 take, flip, armed_nxt, tooth_q, armed_q;
  hys_style_e           style;

  assign smp_ready = 1'b1;
  assign take      = smp_valid && !out_hold;
  assign style     = hys_style_e'(hys_visible);
  assign smp_x     = $signed({smp_data[SMP_W-1], smp_data});

  hhs_levels #(.SMP_W(SMP_W), .HYS_W(HYS_W)) u_lvl (
    .thr_i(thr_level), .hys_i(hys_half),
    .thr_x(thr_x), .up_x(up_x), .lo_x(lo_x)
  );

  hhs_decide #(.SMP_W(SMP_W)) u_dec (
    .take_i(take), .style_i(style), .smp_x(smp_x), .thr_x(thr_x),
    .up_x(up_x), .lo_x(lo_x), .tooth_i(tooth_q), .armed_i(armed_q),
    .flip_o(flip), .armed_nxt_o(armed_nxt)
  );

  hhs_state u_st (
    .clk(clk), .rst_n(rst_n), .hold_i(out_hold), .invert_i(out_invert),
    .flip_i(flip), .armed_nxt_i(armed_nxt),
    .tooth_q(tooth_q), .armed_q(armed_q), .out_q(sw_out), .evt_q(sw_strobe)
  );

  AST_RISE_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tooth_q) && tooth_q) |-> ($past(smp_x) > $past(thr_x)));   // R2
  AST_FALL_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tooth_q) && !tooth_q) |-> ($past(smp_x) < $past(thr_x)));   // R4
  AST_VIS_RISE_ON_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tooth_q) && tooth_q && $past(hys_visible)) |-> ($past(smp_x) > $past(up_x))); // R6
  AST_IDLE_KEEPS_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_valid) |-> ($stable(tooth_q) && $stable(armed_q)));     // R10
  AST_READY_EVERY_CYCLE: assert property (@(posedge clk)
    smp_ready);                                                        // R10
endmodule

// File: tb/sim_hhs_switch.sv
module sim_hhs_switch;
  localparam int SMP_W = 12;
  localparam int HYS_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, hys_visible = 1'b0, out_invert = 1'b0, out_hold = 1'b0;
  logic [SMP_W-1:0] smp_data = '0, thr_level = '0;
  logic [HYS_W-1:0] hys_half = '0;
  logic smp_ready, sw_out, sw_strobe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // model state
  bit m_tooth = 0, m_armed = 0, m_out = 1, m_evt = 0;

  always #4 clk = ~clk;

  hhs_switch #(.SMP_W(SMP_W), .HYS_W(HYS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .thr_level(thr_level), .hys_half(hys_half),
    .hys_visible(hys_visible), .out_invert(out_invert), .out_hold(out_hold),
    .sw_out(sw_out), .sw_strobe(sw_strobe)
  );

  function automatic bit want_flip(bit tooth, bit armed, bit vis, int s, int t, int h);
    bit arm = armed || (s < t - h) || (s > t + h);
    if (vis) return tooth ? (s < t - h) : (s > t + h);
    return tooth ? (arm && s < t) : (arm && s > t);
  endfunction

  function automatic bit arm_after(bit armed, bit flip, int s, int t, int h);
    if (flip) return 1'b0;
    return armed || (s < t - h) || (s > t + h);
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // apply one cycle of stimulus, then compare after the edge
  task automatic step(string tag, bit v, int s, int t, int h, bit vis, bit inv, bit hld);
    bit f, new_out;
    smp_valid = v; smp_data = SMP_W'(s); thr_level = SMP_W'(t);
    hys_half = HYS_W'(h); hys_visible = vis; out_invert = inv; out_hold = hld;
    if (v && !hld) begin
      f = want_flip(m_tooth, m_armed, vis, s, t, h);
      m_armed = arm_after(m_armed, f, s, t, h);
      m_tooth = m_tooth ^ f;
    end
    new_out = hld ? m_out : (inv ? m_tooth : !m_tooth);
    m_evt = new_out != m_out;
    m_out = new_out;
    @(posedge clk);
    @(negedge clk);
    check(tag, sw_out, m_out, "sw_out");
    check(tag, sw_strobe, m_evt, "sw_strobe");
    check("R10", smp_ready, 1'b1, "smp_ready");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", sw_out, 1'b1, "reset out");
    check("R1", sw_strobe, 1'b0, "reset strobe");
    rst_n = 1'b1;
    // hidden style, thr 100, half-width 10
    step("R1", 1, 105, 100, 10, 0, 0, 0);  // inside band, disarmed
    step("R2", 1, 85, 100, 10, 0, 0, 0);   // arms via lower level
    step("R2", 1, 101, 100, 10, 0, 0, 0);  // rise to tooth
    step("R3", 1, 99, 100, 10, 0, 0, 0);
    step("R3", 1, 101, 100, 10, 0, 0, 0);
    step("R3", 1, 95, 100, 10, 0, 0, 0);
    step("R4", 1, 111, 100, 10, 0, 0, 0);  // arms via upper level
    step("R4", 1, 99, 100, 10, 0, 0, 0);   // fall to notch
    step("R3", 1, 105, 100, 10, 0, 0, 0);
    step("R2", 1, 89, 100, 10, 0, 0, 0);
    step("R2", 1, 101, 100, 10, 0, 0, 0);
    step("R5", 1, 95, 100, 10, 0, 0, 0);
    step("R5", 1, 85, 100, 10, 0, 0, 0);   // fallback fall below lower level
    step("R11", 1, 80, 100, 10, 0, 0, 0);
    step("R11", 1, 100, 100, 10, 0, 0, 0); // equal: no switch
    step("R10", 0, 300, 100, 10, 0, 0, 0); // invalid sample ignored
    step("R11", 1, 101, 100, 10, 0, 0, 0);
    // visible style
    step("R6", 1, 95, 100, 10, 1, 0, 0);
    step("R6", 1, 90, 100, 10, 1, 0, 0);   // equal to off level
    step("R6", 1, 89, 100, 10, 1, 0, 0);
    step("R6", 1, 110, 100, 10, 1, 0, 0);  // equal to on level
    step("R6", 1, 111, 100, 10, 1, 0, 0);
    // polarity
    step("R7", 0, 0, 100, 10, 1, 1, 0);
    step("R7", 0, 0, 100, 10, 1, 1, 0);
    step("R7", 1, 50, 100, 10, 1, 1, 0);
    // hold
    step("R8", 1, 150, 100, 10, 1, 1, 1);
    step("R8", 1, 150, 100, 10, 1, 0, 1);
    step("R8", 0, 150, 100, 10, 1, 0, 0);
    step("R8", 1, 150, 100, 10, 1, 0, 0);
    // wide arithmetic near full scale
    step("R11", 1, 2047, 2040, 200, 1, 0, 0);
    step("R11", 1, 1800, 2040, 200, 1, 0, 0);
    step("R11", 1, 1839, 2040, 200, 1, 0, 0);
    // constrained random
    begin
      int seed_v = $urandom(32'h5EED_1234);
      int t = 0, h = 8;
      bit vis = 0, inv = 0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 99) < 3) t = $urandom_range(0, 400) - 200;
        if ($urandom_range(0, 99) < 3) h = $urandom_range(0, 40);
        if ($urandom_range(0, 199) == 0) vis = !vis;
        if ($urandom_range(0, 299) == 0) inv = !inv;
        step(vis ? "R6" : "R2", $urandom_range(0, 99) < 80,
             t + $urandom_range(0, 120) - 60, t, h, vis, inv,
             $urandom_range(0, 99) < 5);
      end
      if (seed_v == 0) t = 0;
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule